// File: doc/BRIEF.md
# Synchronous power-of-two clock divider

This block takes one input clock and produces a set of slower clocks at one half, one quarter and one eighth of its rate. All of them are bits of a single down-counter that advances on the rising edge of the input clock. Because every output comes from the same register stage, their common edges line up exactly. The outputs are plain registered signals in the input-clock domain.

A hold input stops the count cleanly. Hold is captured only on falling edges, while the clock is low, so a stop or a restart can never cut an output pulse short. An asynchronous master reset clears every output. After reset is released, counting restarts with a fixed latency that depends only on the clock level at the moment of release. Several of these blocks can therefore be brought into phase by releasing one shared reset.

Top module: `pow2_clk_divider`

## Requirements
- R1: `div_o[k]` toggles at the input rate divided by 2^(k+1) with 50% duty while counting: bit 0 gives divide-by-2, bit 1 gives divide-by-4 and bit 2 gives divide-by-8.
- R2: Read as a binary number, `div_o` steps down by one, modulo 2^NUM_OUTS, on each counting rising edge. The first step after reset goes from 0 to all ones. Every rising edge of `div_o[k]` falls on the same clock edge as a rising edge of `div_o[k-1]`.
- R3: While `mr_i` is high, `div_o` is all zeros, with no clock edge needed and whatever `hold_i` does.
- R4: If `mr_i` falls while `clk_i` is high and `hold_i` is low, `div_o` stays zero at the first rising edge after release and becomes all ones at the second.
- R5: If `mr_i` falls while `clk_i` is low and `hold_i` is low, `div_o` stays zero at the first and second rising edges after release and becomes all ones at the third.
- R6: `hold_i` is sampled only on falling edges of `clk_i`. If it is high at a falling edge, `div_o` does not change at the rising edge that follows.
- R7: A hold raised after a falling edge, while the clock is low, does not stop the next rising edge from counting. The freeze starts at the falling edge after that and keeps the exact value for as long as it lasts.
- R8: After `hold_i` is lowered, counting resumes only at the rising edge that follows the next falling edge, and it continues from the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| hold_i | input | 1 | Active-high freeze request, captured on falling edges |
| mr_i | input | 1 | Active-high asynchronous master reset |
| div_o | output | NUM_OUTS | Divided clocks; bit k is the input divided by 2^(k+1) |

## Verification
The bench builds the block with its defaults: three outputs and a two-stage release chain. With those values the whole eight-state cycle, including the wrap from 0 back to 7, fits inside a short vector table, and both release latencies, two and three rising edges, are reached by releasing reset in each clock phase. Holds raised in the high and low halves of the clock show exactly which falling edge takes effect for a freeze and for a restart.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Default number of divided outputs (divide by 2 .. 2^N)
  localparam int unsigned DEFAULT_OUTS  = 3;
  // Default depth of the falling-edge reset-release chain
  localparam int unsigned DEFAULT_REL   = 2;
endpackage

// File: rtl/clkdiv_run_gate.sv
// Falling-edge run control: captures the hold request and sequences the
// release from master reset, so that count enable changes only while the
// input clock is low.
module clkdiv_run_gate #(
  parameter int unsigned REL_DEPTH = clkdiv_pkg::DEFAULT_REL
) (
  input  logic clk_i,
  input  logic mr_i,
  input  logic hold_i,
  output logic count_en_o
);
  logic [REL_DEPTH-1:0] rel_q;
  logic                 run_q;

  // Release chain: all ones in reset, shifts zeros in on falling edges
  always_ff @(negedge clk_i or posedge mr_i) begin
    if (mr_i) rel_q <= '1;
    else      rel_q <= rel_q << 1;
  end

  // Hold capture on the falling edge only
  always_ff @(negedge clk_i or posedge mr_i) begin
    if (mr_i) run_q <= 1'b0;
    else      run_q <= ~hold_i;
  end

  assign count_en_o = run_q & ~rel_q[REL_DEPTH-1];
endmodule

// File: rtl/clkdiv_downcount.sv
// Shared down-counter; every divided output is one of its bits.
module clkdiv_downcount #(
  parameter int unsigned WIDTH = clkdiv_pkg::DEFAULT_OUTS
) (
  input  logic             clk_i,
  input  logic             mr_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or posedge mr_i) begin
    if (mr_i)      cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o - ONE;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i) mr_i |=> (cnt_o == '0)); // R3

  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (mr_i)
    (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) - ONE)); // R2
endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider #(
  parameter int unsigned NUM_OUTS      = clkdiv_pkg::DEFAULT_OUTS,
  parameter int unsigned RELEASE_DEPTH = clkdiv_pkg::DEFAULT_REL
) (
  input  logic                clk_i,
  input  logic                hold_i,
  input  logic                mr_i,
  output logic [NUM_OUTS-1:0] div_o
);
  logic                count_en;
  logic [NUM_OUTS-1:0] cnt;

  clkdiv_run_gate #(.REL_DEPTH(RELEASE_DEPTH)) u_gate (
    .clk_i      (clk_i),
    .mr_i       (mr_i),
    .hold_i     (hold_i),
    .count_en_o (count_en)
  );

  clkdiv_downcount #(.WIDTH(NUM_OUTS)) u_cnt (
    .clk_i (clk_i),
    .mr_i  (mr_i),
    .en_i  (count_en),
    .cnt_o (cnt)
  );

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
    assign div_o[k] = cnt[k];
    if (k > 0) begin : g_align
      AST_EDGE_ALIGN: assert property (@(posedge clk_i) disable iff (mr_i)
        $rose(div_o[k]) |-> $rose(div_o[k-1])); // R2
    end
  end

  AST_HOLD_FREEZE: assert property (@(negedge clk_i) disable iff (mr_i)
    hold_i |=> $stable(div_o)); // R6
endmodule

// File: tb/tb_pow2_clk_divider.sv
module tb_pow2_clk_divider;
  logic       clk = 1'b0;
  logic       hold = 1'b0;
  logic       mr = 1'b1;
  logic [2:0] div;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  pow2_clk_divider dut (.clk_i(clk), .hold_i(hold), .mr_i(mr), .div_o(div));

  always #4 clk = ~clk;   // 125 MHz

  // {hold for this cycle, expected div after the next rising edge}
  localparam logic [3:0] VEC [16] = '{
    4'b0_110, 4'b0_101, 4'b1_101, 4'b1_101,
    4'b0_100, 4'b0_011, 4'b0_010, 4'b1_010,
    4'b0_001, 4'b0_000, 4'b0_111, 4'b1_111,
    4'b1_111, 4'b1_111, 4'b0_110, 4'b0_101
  };

  task automatic to_phase(input int ns);
    @(posedge clk);
    #ns;
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if (div !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", req, div, exp, $time);
    end
  endtask

  initial begin
    // R3: reset state
    repeat (3) to_phase(1);
    check("R3 reset state", 3'b000);

    // R4: release while clock high
    to_phase(1);
    mr = 1'b0;
    to_phase(1); check("R4 first edge", 3'b000);
    to_phase(1); check("R4 second edge", 3'b111);
    to_phase(1); check("R2 R1 step", 3'b110);

    // R3: asynchronous clear, hold ignored in reset
    to_phase(2);
    mr = 1'b1;
    #1 check("R3 async clear", 3'b000);
    hold = 1'b1;
    repeat (3) to_phase(1);
    check("R3 hold ignored in reset", 3'b000);
    hold = 1'b0;

    // R5: release while clock low
    to_phase(5);
    mr = 1'b0;
    to_phase(1); check("R5 first edge", 3'b000);
    to_phase(1); check("R5 second edge", 3'b000);
    to_phase(1); check("R5 third edge", 3'b111);

    // R1 R2 R6 R8: vector walk with wrap 0 -> 7
    for (int i = 0; i < 16; i++) begin
      hold = VEC[i][3];
      to_phase(1);
      check("R1 R2 R6 R8 vector", VEC[i][2:0]);
    end

    // R7: hold raised while clock low
    to_phase(5);                 // count 5 -> 4 at this edge
    hold = 1'b1;
    to_phase(1); check("R7 late hold still counts", 3'b011);
    to_phase(1); check("R7 frozen", 3'b011);
    // R8: hold lowered while clock low
    to_phase(5);
    hold = 1'b0;
    to_phase(1); check("R8 waits for falling edge", 3'b011);
    to_phase(1); check("R8 resumes from frozen value", 3'b010);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule